// File: doc/BRIEF.md
# Dual-Pixel Line Splitter into Left and Right Stripes

This block accepts a video stream that carries two adjacent pixels on every valid beat and turns each line into two single-pixel streams. The first output stream carries the left half of every line and the second carries the right half, so a wide panel that is driven as two side-by-side stripes can be fed from a source that only produces paired pixels. Every beat is steered by its column position into one of two per-stripe FIFOs. No frame store is kept: each FIFO holds half a line at most, which is one line in total.

A compile-time switch selects how the two FIFOs drain. In aligned mode, reading starts only once both FIFOs hold data, and both outputs then step together. In independent mode, each FIFO drains as soon as it has data. Each stream emits one pixel per clock while it drains. It marks the first pixel of each stripe row as a line start. It also marks that pixel as a frame start when the row is the first of a frame. A single sticky error flag records any FIFO overflow and any stripe that runs dry in the middle of a row.

Top module: `stripe_splitter`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, both output valids and the error flag are low.
- R2: For a line of `LINE_W` pixels, where beat k carries pixel 2k on `in_pix_even` and pixel 2k+1 on `in_pix_odd`, output A emits pixels 0 to `LINE_W/2-1` in ascending order.
- R3: Output B emits pixels `LINE_W/2` to `LINE_W-1` of the same line in ascending order.
- R4: The line-start output is high only on the first pixel of each stripe row. The frame-start output is high only on that pixel, and only for the row whose first input beat had both `in_sol` and `in_sof` set.
- R5: When `SYNC` is 1, the two output valids are equal on every clock, and output A emits nothing before the first beat of the right half has arrived.
- R6: When `SYNC` is 0, output A starts emitting before the right half of the line has arrived.
- R7: Once a stripe row has started, its output is valid on every clock until all `LINE_W/2` pixels of that row have been emitted, provided the input stays within the FIFO limits.
- R8: A beat that finds its FIFO too full to take two more pixels is dropped and sets the error flag. The flag then stays high until reset.
- R9: A stripe whose row has started and that has no pixel to emit sets the sticky error flag (underflow).
- R10: Beats that arrive after the `LINE_W/2` beats of a line and before the next line start are discarded and produce no output pixel.
- R11: With full lines separated by at least `LINE_W/2` idle clocks, the error flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_sol | input | 1 | First beat of a line |
| in_sof | input | 1 | First line of a frame (read together with `in_sol`) |
| in_pix_even | input | PIX_W | Even-indexed pixel of the pair |
| in_pix_odd | input | PIX_W | Odd-indexed pixel of the pair |
| a_pix | output | PIX_W | Left stripe pixel |
| a_valid | output | 1 | Left stripe pixel valid |
| a_sol | output | 1 | Left stripe row start |
| a_sof | output | 1 | Left stripe frame start |
| b_pix | output | PIX_W | Right stripe pixel |
| b_valid | output | 1 | Right stripe pixel valid |
| b_sol | output | 1 | Right stripe row start |
| b_sof | output | 1 | Right stripe frame start |
| err | output | 1 | Sticky overflow or underflow flag |

## Verification
The assertions check on every clock that the valids of the two stripes move in lockstep in aligned mode, that the error flag never clears on its own, that a frame start only appears together with a valid line start, that the outputs are quiet on leaving reset, and that no valid pixel carries unknown bits. Only the bench scenarios can show the contents and order of each half line, the discarding of surplus beats, the early release in independent mode, and that overflow and a mid-row starvation raise the flag. The bench drives numbered pixels into both an aligned and an independent instance, and compares every emitted pixel and marker against queues of expected values.

// File: rtl/stripe_splitter.sv
module stripe_splitter #(
  parameter int LINE_W  = 3840,
  parameter int PIX_W   = 24,
  parameter bit SYNC    = 1'b1,
  parameter int FIFO_PX = LINE_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic             in_sof,
  input  logic [PIX_W-1:0] in_pix_even,
  input  logic [PIX_W-1:0] in_pix_odd,
  output logic [PIX_W-1:0] a_pix,
  output logic             a_valid,
  output logic             a_sol,
  output logic             a_sof,
  output logic [PIX_W-1:0] b_pix,
  output logic             b_valid,
  output logic             b_sol,
  output logic             b_sof,
  output logic             err
);
  localparam int HALF  = LINE_W / 2;
  localparam int QB    = LINE_W / 4;
  localparam int PAIRS = FIFO_PX / 2;
  localparam int AW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam int CW    = $clog2(FIFO_PX + 1);
  localparam int LW    = $clog2(HALF + 1);
  localparam int OW    = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int EW    = 2 * PIX_W + 2;

  logic [LW-1:0] col_q;
  logic          row0_q;

  wire [LW-1:0] col     = in_sol ? '0 : col_q;
  wire          in_line = col < LW'(2 * QB);
  wire          side    = col >= LW'(QB);
  wire          first   = (col == '0) || (col == LW'(QB));
  wire          row0    = in_sol ? in_sof : row0_q;
  wire [EW-1:0] entry   = {row0, first, in_pix_odd, in_pix_even};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      col_q  <= '0;
      row0_q <= 1'b0;
    end else if (in_valid) begin
      col_q  <= in_line ? col + LW'(1) : col;
      row0_q <= row0;
    end

  logic [1:0] nz, pop, ovf, udf;

  for (genvar s = 0; s < 2; s++) begin : st
    logic [EW-1:0]    mem [PAIRS];
    logic [AW-1:0]    wp, rp;
    logic             rh;
    logic [CW-1:0]    cnt;
    logic [OW-1:0]    ocol;
    logic [PIX_W-1:0] o_pix;
    logic             o_val, o_sol, o_sof;

    wire          wr   = in_valid && in_line && (side == s[0]);
    wire [EW-1:0] head = mem[rp];

    assign nz[s]  = cnt != '0;
    assign pop[s] = SYNC ? (nz[0] && nz[1]) : nz[s];
    assign ovf[s] = wr && (({1'b0, cnt} + (CW+1)'(2)) > ((CW+1)'(FIFO_PX) + (CW+1)'(pop[s])));
    assign udf[s] = (ocol != '0) && !pop[s];

    wire wr_ok = wr && !ovf[s];

    always_ff @(posedge clk)
      if (wr_ok) mem[wp] <= entry;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp    <= '0;
        rp    <= '0;
        rh    <= 1'b0;
        cnt   <= '0;
        ocol  <= '0;
        o_pix <= '0;
        o_val <= 1'b0;
        o_sol <= 1'b0;
        o_sof <= 1'b0;
      end else begin
        if (wr_ok) wp <= (wp == AW'(PAIRS - 1)) ? '0 : wp + AW'(1);
        cnt   <= cnt + (wr_ok ? CW'(2) : CW'(0)) - CW'(pop[s]);
        o_val <= pop[s];
        if (pop[s]) begin
          rh    <= ~rh;
          if (rh) rp <= (rp == AW'(PAIRS - 1)) ? '0 : rp + AW'(1);
          ocol  <= (ocol == OW'(HALF - 1)) ? '0 : ocol + OW'(1);
          o_pix <= rh ? head[2*PIX_W-1:PIX_W] : head[PIX_W-1:0];
          o_sol <= head[EW-2] && !rh;
          o_sof <= head[EW-1] && head[EW-2] && !rh;
        end else begin
          o_sol <= 1'b0;
          o_sof <= 1'b0;
        end
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) err <= 1'b0;
    else        err <= err | (|ovf) | (|udf);

  assign a_pix   = st[0].o_pix;
  assign a_valid = st[0].o_val;
  assign a_sol   = st[0].o_sol;
  assign a_sof   = st[0].o_sof;
  assign b_pix   = st[1].o_pix;
  assign b_valid = st[1].o_val;
  assign b_sol   = st[1].o_sol;
  assign b_sof   = st[1].o_sof;
endmodule

// File: rtl/stripe_splitter_chk.sv
module stripe_splitter_chk #(
  parameter bit SYNC  = 1'b1,
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PIX_W-1:0] a_pix,
  input logic             a_valid,
  input logic             a_sol,
  input logic             a_sof,
  input logic [PIX_W-1:0] b_pix,
  input logic             b_valid,
  input logic             b_sol,
  input logic             b_sof,
  input logic             err
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!a_valid && !b_valid && !err));

  assert_known_pix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid |-> !$isunknown(a_pix));

  assert_known_pix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    b_valid |-> !$isunknown(b_pix));

  assert_sof_marks_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    a_sof |-> (a_valid && a_sol));

  assert_sof_marks_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    b_sof |-> (b_valid && b_sol));

  assert_lockstep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    SYNC |-> (a_valid == b_valid));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind stripe_splitter stripe_splitter_chk #(.SYNC(SYNC), .PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_pix(a_pix), .a_valid(a_valid), .a_sol(a_sol), .a_sof(a_sof),
  .b_pix(b_pix), .b_valid(b_valid), .b_sol(b_sol), .b_sof(b_sof),
  .err(err)
);

// File: tb/sim_stripe_splitter.sv
module sim_stripe_splitter;
  localparam int LINE_W = 16;
  localparam int HALF   = LINE_W / 2;
  localparam int QB     = LINE_W / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
  logic [23:0] in_even = '0, in_odd = '0;

  logic [23:0] pix [4];
  logic        vld [4];
  logic        sol [4];
  logic        sof [4];
  logic        err0, err1;

  always #10 clk = ~clk;

  stripe_splitter #(.LINE_W(LINE_W), .SYNC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
    .in_pix_even(in_even), .in_pix_odd(in_odd),
    .a_pix(pix[0]), .a_valid(vld[0]), .a_sol(sol[0]), .a_sof(sof[0]),
    .b_pix(pix[1]), .b_valid(vld[1]), .b_sol(sol[1]), .b_sof(sof[1]), .err(err0));

  stripe_splitter #(.LINE_W(LINE_W), .SYNC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof),
    .in_pix_even(in_even), .in_pix_odd(in_odd),
    .a_pix(pix[2]), .a_valid(vld[2]), .a_sol(sol[2]), .a_sof(sof[2]),
    .b_pix(pix[3]), .b_valid(vld[3]), .b_sol(sol[3]), .b_sof(sof[3]), .err(err1));

  int n_chk = 0, n_fail = 0;
  logic [25:0] q [4][$];
  int ocol [4];
  bit chk_en = 1'b0;
  bit seen [4];
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] pv(input int row, input int col);
    return {row[11:0], col[11:0]};
  endfunction

  task automatic mon(input int i);
    logic [25:0] e;
    if (vld[i]) begin
      seen[i] = 1'b1;
      if (q[i].size() == 0) begin
        check(1'b0, $sformatf("R2 R3 R10 unexpected pixel on stream %0d", i), {8'h0, pix[i]}, 32'hFFFFFFFF);
      end else begin
        e = q[i].pop_front();
        check(pix[i] == e[23:0], $sformatf("R2 R3 pixel stream %0d", i), {8'h0, pix[i]}, {8'h0, e[23:0]});
        check({sof[i], sol[i]} == e[25:24], $sformatf("R4 markers stream %0d", i),
              {30'h0, sof[i], sol[i]}, {30'h0, e[25:24]});
      end
      ocol[i] = (ocol[i] + 1) % HALF;
    end else begin
      check(ocol[i] == 0, $sformatf("R7 gap mid-row stream %0d", i), 32'(ocol[i]), 32'h0);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en && rst_n) begin
      check(vld[0] == vld[1], "R5 lockstep valids", {31'h0, vld[0]}, {31'h0, vld[1]});
      for (int i = 0; i < 4; i++) mon(i);
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
    end
  endtask

  task automatic send(input int row, input bit fs, input int nbeats, input int extra, input int gap);
    for (int k = 0; k < nbeats + extra; k++) begin
      if (k == QB && row == 0 && fs && chk_en) begin
        check(seen[2], "R6 independent A released before right half", {31'h0, seen[2]}, 32'h1);
        check(!seen[0], "R5 aligned A held until right half", {31'h0, seen[0]}, 32'h0);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sol   = (k == 0);
      in_sof   = (k == 0) && fs;
      in_even  = pv(row, 2 * k);
      in_odd   = pv(row, 2 * k + 1);
      if (k < nbeats) begin
        for (int p = 0; p < 2; p++) begin
          int c = 2 * k + p;
          bit f = (c == 0) || (c == HALF);
          logic [25:0] e = {fs && f, f, pv(row, c)};
          if (c < HALF) begin q[0].push_back(e); q[2].push_back(e); end
          else          begin q[1].push_back(e); q[3].push_back(e); end
        end
      end
      if (k == 0 && gap > 0) idle(gap);
    end
    idle(1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin q[i].delete(); ocol[i] = 0; seen[i] = 1'b0; end
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin ocol[i] = 0; seen[i] = 1'b0; end
    idle(3);
    for (int i = 0; i < 4; i++)
      check(!vld[i], "R1 valid low in reset", {31'h0, vld[i]}, 32'h0);
    check(!err0 && !err1, "R1 err low in reset", {30'h0, err1, err0}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4; i++)
      check(!vld[i], "R1 valid low after release", {31'h0, vld[i]}, 32'h0);

    chk_en = 1'b1;
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < 3; r++) begin
        send(f * 100 + r, r == 0, 2 * QB, (r == 1) ? 3 : 0, 0);
        idle(LINE_W);
      end
    idle(LINE_W);
    for (int i = 0; i < 4; i++)
      check(q[i].size() == 0, $sformatf("R2 R3 all pixels delivered stream %0d", i), 32'(q[i].size()), 32'h0);
    check(!err0, "R11 aligned err stays low", {31'h0, err0}, 32'h0);
    check(!err1, "R11 independent err stays low", {31'h0, err1}, 32'h0);
    chk_en = 1'b0;

    do_reset();
    send(7, 1'b0, QB, 0, 0);
    idle(4);
    send(8, 1'b0, QB, 0, 0);
    idle(2);
    check(err0, "R8 overflow sets err", {31'h0, err0}, 32'h1);
    check(!err1, "R8 no overflow when draining", {31'h0, err1}, 32'h0);
    idle(LINE_W);
    check(err0, "R8 err sticky", {31'h0, err0}, 32'h1);

    do_reset();
    send(9, 1'b1, 2 * QB, 0, 6);
    idle(LINE_W);
    check(err1, "R9 underflow sets err", {31'h0, err1}, 32'h1);
    check(!err0, "R9 aligned stream not starved", {31'h0, err0}, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule